// File: doc/BRIEF.md
# Parallel flash write-cycle sequencer

This block turns one host write request into a single asynchronous write bus cycle on a parallel NOR-style flash device. It counts clock cycles to meet the device's timing limits:

- the recovery interval after reset,
- address and data setup,
- the minimum low and high widths of the write-enable pulse,
- the window after the pulse in which the ready/busy status pin must not be trusted,
- the wait for the device to report ready,
- a write-recovery interval before the host may start another bus cycle.

Every interval is given as a nanosecond parameter, together with the clock period. Each one is converted to cycles by rounding up, with at least one cycle per phase. The reset-recovery time depends on device density: 150, 180 or 210 ns for 32, 64 or 128 Mbit.

The host side is a valid/ready stream. The payload is an address and a data word. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must hold `req_valid` and its payload stable until that edge. `req_ready` is high only when the sequencer is idle and reset recovery has elapsed, so the host is held off for the whole bus cycle. The device status input passes through a synchronizer before use. If the device never reports ready, a timeout ends the wait and sets a sticky `wr_timeout` flag. The next accepted request clears the flag.

Top module: `flash_wr_seq`

## Requirements
- R1: After reset is released, `req_ready` stays low for exactly ceil(T_rst / CLK_NS) samples, with T_rst = 150, 180 or 210 ns for DENSITY_MBIT 32, 64 or 128 (any other value uses 210). `flash_we_n` never falls before this interval has elapsed.
- R2: Each write pulse holds `flash_we_n` low for exactly ceil(T_WP_NS / CLK_NS) cycles (6 at the defaults).
- R3: `flash_ce_n` is low during the setup and pulse phases, is never high while `flash_we_n` is low, and rises on the same cycle as `flash_we_n`. `flash_we_n` stays high for at least ceil(T_WPH_NS / CLK_NS) cycles between two pulses.
- R4: On acceptance, the request's address and data appear on `flash_addr` and `flash_dq_o` with `flash_dq_oe` high. The setup phase lasts max(1, ceil(max(T_AS_NS, T_DS_NS) / CLK_NS) − pulse cycles) cycles (1 at the defaults). Address and data stay unchanged through the pulse.
- R5: `flash_vpen` rises at the start of the setup phase. It stays high until the synchronized status has been seen high in the wait-for-ready phase, or until the timeout.
- R6: Status is ignored for ceil(T_WPH_NS / CLK_NS) + ceil(T_BUSY_NS / CLK_NS) cycles after `flash_we_n` rises (3 + 50 at the defaults). `flash_sts` passes through SYNC_STAGES flip-flops before the sequencer sees it.
- R7: After a normal completion, `req_ready` stays low for ceil(T_WR_NS / CLK_NS) cycles after `flash_vpen` falls (4 at the defaults). `flash_oe_n` is never driven low.
- R8: If status stays low for TIMEOUT_CYC cycles in the wait-for-ready phase, the sequencer returns straight to idle with no recovery phase and sets `wr_timeout`. `wr_timeout` stays set until the next accepted request clears it.
- R9: `req_ready` is low from acceptance until the cycle sequence ends. A request that the host presents during that time is not taken, and `flash_addr` keeps the address of the write in progress.
- R10: While reset is held, `flash_ce_n`, `flash_we_n` and `flash_oe_n` are high, and `flash_vpen`, `flash_dq_oe` and `req_ready` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low, held high |
| flash_addr | output | AW | Address bus |
| flash_dq_o | output | DW | Data bus output value |
| flash_dq_oe | output | 1 | Data bus output enable |
| flash_vpen | output | 1 | Program-enable supply control |
| flash_sts | input | 1 | Device ready (1) / busy (0) |
| wr_timeout | output | 1 | Sticky flag: the last write timed out waiting for ready |

## Verification
The hardest case to reach from the ports is a status return that lands close to the end of the ignore window. The case is made harder because the return passes through the synchronizer first. If the status returns inside the window, it must have no effect. If it returns one cycle later, it must lengthen the wait by exactly one cycle. The bench drives `flash_sts` from its own cycle count, measured from the sample where write enable rises. It sweeps the return point from before that rise to well past the window, and predicts the length of the program-enable interval as the later of the window end and the return point plus the synchronizer depth. A status line that never returns drives the timeout path.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_SETUP      = 3'd1,
    ST_PULSE_LOW  = 3'd2,
    ST_PULSE_HIGH = 3'd3,
    ST_WAIT_BUSY  = 3'd4,
    ST_WAIT_READY = 3'd5,
    ST_RECOVER    = 3'd6
  } wr_state_e;

  // Round a nanosecond interval up to whole clock cycles, at least one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Reset-recovery time chosen by device density in Mbit.
  function automatic int unsigned rst_recovery_ns(input int unsigned mbit);
    case (mbit)
      32:      return 150;
      64:      return 180;
      default: return 210;
    endcase
  endfunction

endpackage

// File: rtl/flash_wr_rstgate.sv
module flash_wr_rstgate #(
  parameter int unsigned CYC = 21
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int unsigned W = $clog2(CYC + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (cnt_q != W'(CYC))  cnt_q <= cnt_q + W'(1);
  end

  assign done = (cnt_q == W'(CYC));

  AST_RECOVERY_STAYS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R1

endmodule

// File: rtl/flash_wr_sync.sv
module flash_wr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/flash_wr_timer.sv
module flash_wr_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/flash_wr_fsm.sv
module flash_wr_fsm
  import flash_wr_pkg::*;
#(
  parameter int unsigned AW          = 24,
  parameter int unsigned DW          = 16,
  parameter int unsigned SETUP_CYC   = 1,
  parameter int unsigned WP_CYC      = 6,
  parameter int unsigned WPH_CYC     = 3,
  parameter int unsigned BUSY_CYC    = 50,
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter int unsigned WR_CYC      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          recovered,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          sts_s,
  output logic          req_ready,
  output logic          ce_n,
  output logic          we_n,
  output logic          dq_oe,
  output logic          vpen,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          timeout_flag
);
  localparam int unsigned MAXC = umax(umax(umax(SETUP_CYC, WP_CYC), umax(WPH_CYC, BUSY_CYC)),
                                      umax(TIMEOUT_CYC, WR_CYC));
  localparam int unsigned TW   = $clog2(MAXC + 1);

  wr_state_e      state_q, state_d;
  logic           tmr_load;
  logic [TW-1:0]  tmr_val;
  logic           tmr_exp;
  logic           accept;
  logic           set_to;

  flash_wr_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  assign accept = req_valid && req_ready;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    set_to   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_SETUP; tmr_load = 1'b1; tmr_val = TW'(SETUP_CYC - 1);
      end
      ST_SETUP: if (tmr_exp) begin
        state_d = ST_PULSE_LOW; tmr_load = 1'b1; tmr_val = TW'(WP_CYC - 1);
      end
      ST_PULSE_LOW: if (tmr_exp) begin
        state_d = ST_PULSE_HIGH; tmr_load = 1'b1; tmr_val = TW'(WPH_CYC - 1);
      end
      ST_PULSE_HIGH: if (tmr_exp) begin
        state_d = ST_WAIT_BUSY; tmr_load = 1'b1; tmr_val = TW'(BUSY_CYC - 1);
      end
      ST_WAIT_BUSY: if (tmr_exp) begin
        state_d = ST_WAIT_READY; tmr_load = 1'b1; tmr_val = TW'(TIMEOUT_CYC - 1);
      end
      ST_WAIT_READY: begin
        if (sts_s) begin
          state_d = ST_RECOVER; tmr_load = 1'b1; tmr_val = TW'(WR_CYC - 1);
        end else if (tmr_exp) begin
          state_d = ST_IDLE; set_to = 1'b1;
        end
      end
      ST_RECOVER: if (tmr_exp) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      data_q       <= '0;
      timeout_flag <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q       <= req_addr;
        data_q       <= req_data;
        timeout_flag <= 1'b0;
      end else if (set_to) begin
        timeout_flag <= 1'b1;
      end
    end
  end

  // Output decode from the registered state.
  assign req_ready = recovered && (state_q == ST_IDLE);
  assign ce_n      = !((state_q == ST_SETUP) || (state_q == ST_PULSE_LOW));
  assign we_n      = (state_q != ST_PULSE_LOW);
  assign dq_oe     = (state_q == ST_SETUP) || (state_q == ST_PULSE_LOW) ||
                     (state_q == ST_PULSE_HIGH);
  assign vpen      = (state_q == ST_SETUP) || (state_q == ST_PULSE_LOW) ||
                     (state_q == ST_PULSE_HIGH) || (state_q == ST_WAIT_BUSY) ||
                     (state_q == ST_WAIT_READY);

  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n); // R3
  AST_CE_RISES_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ce_n); // R3
  AST_BUS_HELD_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe && $stable(addr_q) && $stable(data_q))); // R4
  AST_VPEN_AT_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> vpen); // R5
  AST_VPEN_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vpen) |-> ($past(sts_s) || timeout_flag)); // R5
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !accept) |=> timeout_flag); // R8
  AST_ADDR_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> $past(accept)); // R9

endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
  import flash_wr_pkg::*;
#(
  parameter int unsigned AW           = 24,
  parameter int unsigned DW           = 16,
  parameter int unsigned CLK_NS       = 10,
  parameter int unsigned DENSITY_MBIT = 128,
  parameter int unsigned T_WP_NS      = 60,
  parameter int unsigned T_WPH_NS     = 30,
  parameter int unsigned T_AS_NS      = 55,
  parameter int unsigned T_DS_NS      = 50,
  parameter int unsigned T_WR_NS      = 35,
  parameter int unsigned T_BUSY_NS    = 500,
  parameter int unsigned TIMEOUT_CYC  = 100000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          flash_ce_n,
  output logic          flash_we_n,
  output logic          flash_oe_n,
  output logic [AW-1:0] flash_addr,
  output logic [DW-1:0] flash_dq_o,
  output logic          flash_dq_oe,
  output logic          flash_vpen,
  input  logic          flash_sts,
  output logic          wr_timeout
);
  localparam int unsigned RST_CYC   = ns_to_cyc(rst_recovery_ns(DENSITY_MBIT), CLK_NS);
  localparam int unsigned WP_CYC    = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int unsigned WPH_CYC   = ns_to_cyc(T_WPH_NS, CLK_NS);
  localparam int unsigned SU_TOTAL  = ns_to_cyc(umax(T_AS_NS, T_DS_NS), CLK_NS);
  localparam int unsigned SETUP_CYC = (SU_TOTAL > WP_CYC) ? (SU_TOTAL - WP_CYC) : 1;
  localparam int unsigned BUSY_CYC  = ns_to_cyc(T_BUSY_NS, CLK_NS);
  localparam int unsigned WR_CYC    = ns_to_cyc(T_WR_NS, CLK_NS);
  localparam int unsigned TO_CYC    = (TIMEOUT_CYC < 1) ? 1 : TIMEOUT_CYC;
  localparam int unsigned SYNC_N    = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic rec_done;
  logic sts_s;

  flash_wr_rstgate #(.CYC(RST_CYC)) u_rstgate (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (rec_done)
  );

  flash_wr_sync #(.STAGES(SYNC_N)) u_sts_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (flash_sts),
    .q     (sts_s)
  );

  flash_wr_fsm #(
    .AW          (AW),
    .DW          (DW),
    .SETUP_CYC   (SETUP_CYC),
    .WP_CYC      (WP_CYC),
    .WPH_CYC     (WPH_CYC),
    .BUSY_CYC    (BUSY_CYC),
    .TIMEOUT_CYC (TO_CYC),
    .WR_CYC      (WR_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .recovered    (rec_done),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_data     (req_data),
    .sts_s        (sts_s),
    .req_ready    (req_ready),
    .ce_n         (flash_ce_n),
    .we_n         (flash_we_n),
    .dq_oe        (flash_dq_oe),
    .vpen         (flash_vpen),
    .addr_q       (flash_addr),
    .data_q       (flash_dq_o),
    .timeout_flag (wr_timeout)
  );

  // This block issues no reads, so the output enable is never asserted.
  assign flash_oe_n = 1'b1;

  AST_WE_AFTER_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |-> rec_done); // R1

endmodule

// File: tb/flash_wr_seq_bench.sv
module flash_wr_seq_bench;
  localparam int AW = 24, DW = 16, TO = 40, SYNC = 2, CLK = 10;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_RST128 = (210 + CLK - 1) / CLK;
  localparam int E_RST64  = (180 + CLK - 1) / CLK;
  localparam int E_RST32  = (150 + CLK - 1) / CLK;
  localparam int E_WP     = (60 + CLK - 1) / CLK;
  localparam int E_WPH    = (30 + CLK - 1) / CLK;
  localparam int E_SUT    = (55 + CLK - 1) / CLK;
  localparam int E_SU     = (E_SUT > E_WP) ? E_SUT - E_WP : 1;
  localparam int E_BUSY   = (500 + CLK - 1) / CLK;
  localparam int E_WR     = (35 + CLK - 1) / CLK;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic flash_sts;
  logic req_ready, flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe, flash_vpen, wr_timeout;
  logic [AW-1:0] flash_addr;
  logic [DW-1:0] flash_dq_o;

  logic rdy64, ce64, we64, oe64, dqoe64, vp64, to64;
  logic [AW-1:0] ad64;
  logic [DW-1:0] dq64;
  logic rdy32, ce32, we32, oe32, dqoe32, vp32, to32;
  logic [AW-1:0] ad32;
  logic [DW-1:0] dq32;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  flash_wr_seq #(.AW(AW), .DW(DW), .CLK_NS(CLK), .TIMEOUT_CYC(TO), .SYNC_STAGES(SYNC))
  u_flash_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .flash_ce_n(flash_ce_n),
    .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n), .flash_addr(flash_addr),
    .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe), .flash_vpen(flash_vpen),
    .flash_sts(flash_sts), .wr_timeout(wr_timeout));

  flash_wr_seq #(.AW(AW), .DW(DW), .CLK_NS(CLK), .DENSITY_MBIT(64))
  u_flash_wr_seq_d64 (
    .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_ready(rdy64),
    .req_addr('0), .req_data('0), .flash_ce_n(ce64), .flash_we_n(we64),
    .flash_oe_n(oe64), .flash_addr(ad64), .flash_dq_o(dq64), .flash_dq_oe(dqoe64),
    .flash_vpen(vp64), .flash_sts(1'b1), .wr_timeout(to64));

  flash_wr_seq #(.AW(AW), .DW(DW), .CLK_NS(CLK), .DENSITY_MBIT(32))
  u_flash_wr_seq_d32 (
    .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_ready(rdy32),
    .req_addr('0), .req_data('0), .flash_ce_n(ce32), .flash_we_n(we32),
    .flash_oe_n(oe32), .flash_addr(ad32), .flash_dq_o(dq32), .flash_dq_oe(dqoe32),
    .flash_vpen(vp32), .flash_sts(1'b1), .wr_timeout(to32));

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] pa(input int i);
    return AW'(i * 24'h010203) ^ 24'h5AA5C3;
  endfunction

  function automatic logic [DW-1:0] pd(input int i);
    if (i == 1) return '1;
    if (i == 2) return '0;
    return DW'(i * 16'h0101) ^ 16'hA5A5;
  endfunction

  // R3: minimum high time of write enable between pulses
  int  hi_run = 0;
  logic prev_we = 1'b1;
  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      hi_run  = 0;
      prev_we = 1'b1;
    end else begin
      if (prev_we && !flash_we_n)
        check(hi_run >= E_WPH, "R3", "we_n high run before pulse", hi_run, E_WPH);
      if (flash_we_n) hi_run++;
      else            hi_run = 0;
      prev_we = flash_we_n;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Sample points are 1 ns after a falling clock edge.
  task automatic do_write(input int idx, input int L, input bit exp_to, input bit keep);
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int s, w, v, j, rc, exp_v;
    bit ok_su, ok_pl, busy_ok, oe_ok;
    a = pa(idx);
    d = pd(idx);
    req_valid = 1'b1;
    req_addr  = a;
    req_data  = d;
    while (!req_ready) step();
    step();
    if (keep) begin
      req_addr = pa(idx + 1);
      req_data = pd(idx + 1);
    end else begin
      req_valid = 1'b0;
    end
    check(wr_timeout == 1'b0, "R8", "flag cleared on accept", wr_timeout, 0);
    s = 0; ok_su = 1'b1;
    while (flash_we_n && s < 100) begin
      if (flash_ce_n || !flash_dq_oe || !flash_vpen || flash_addr != a || flash_dq_o != d)
        ok_su = 1'b0;
      s++;
      step();
    end
    check(s == E_SU, "R4", "setup samples", s, E_SU);
    check(ok_su, "R4", "setup bus/enables (R5 vpen)", ok_su, 1);
    w = 0; ok_pl = 1'b1;
    while (!flash_we_n && w < 100) begin
      if (flash_ce_n || !flash_dq_oe || !flash_vpen || flash_addr != a || flash_dq_o != d)
        ok_pl = 1'b0;
      w++;
      step();
    end
    check(w == E_WP, "R2", "we_n low samples", w, E_WP);
    check(ok_pl, "R4", "pulse bus held", ok_pl, 1);
    check(flash_ce_n == 1'b1, "R3", "ce_n rises with we_n", flash_ce_n, 1);
    flash_sts = (L == 0);
    j = 0; v = 0; busy_ok = 1'b1;
    while (flash_vpen && v < 1000) begin
      v++;
      if (req_ready) busy_ok = 1'b0;
      step();
      j++;
      if (L > 0 && j == L) flash_sts = 1'b1;
    end
    if (exp_to) exp_v = E_WPH + E_BUSY + TO;
    else        exp_v = ((E_WPH + E_BUSY) > (L + SYNC) ? (E_WPH + E_BUSY) : (L + SYNC)) + 1;
    if (exp_to)
      check(v == exp_v, "R8", "vpen samples on timeout", v, exp_v);
    else if (L + SYNC <= E_WPH + E_BUSY)
      check(v == exp_v, "R6", "vpen samples, early status ignored", v, exp_v);
    else
      check(v == exp_v, "R5", "vpen held until status ready", v, exp_v);
    check(busy_ok, "R9", "ready low while busy", busy_ok, 1);
    check(flash_addr == a, "R9", "address kept while busy", flash_addr, a);
    rc = 0; oe_ok = 1'b1;
    while (!req_ready && rc < 1000) begin
      if (!flash_oe_n) oe_ok = 1'b0;
      rc++;
      step();
    end
    check(rc == (exp_to ? 0 : E_WR), exp_to ? "R8" : "R7", "recovery samples",
          rc, exp_to ? 0 : E_WR);
    check(oe_ok && flash_oe_n, "R7", "oe_n never low", oe_ok, 1);
    check(wr_timeout == exp_to, "R8", "timeout flag", wr_timeout, exp_to);
    flash_sts = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R9 run did not finish actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int r128, r64, r32, n;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_data  = '0;
    flash_sts = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(flash_ce_n && flash_we_n && flash_oe_n, "R10", "enables high in reset", flash_ce_n, 1);
    check(!flash_vpen && !flash_dq_oe && !req_ready, "R10", "vpen/dq_oe/ready low in reset",
          flash_vpen, 0);
    @(negedge clk);
    rst_n     = 1'b1;
    req_valid = 1'b1;
    req_addr  = pa(0);
    req_data  = pd(0);
    #1;
    r128 = 0; r64 = 0; r32 = 0; n = 0;
    while ((!req_ready || !rdy64 || !rdy32) && n < 100) begin
      if (!req_ready) r128++;
      if (!rdy64)     r64++;
      if (!rdy32)     r32++;
      n++;
      step();
    end
    check(r128 == E_RST128, "R1", "recovery 128 Mbit", r128, E_RST128);
    check(r64  == E_RST64,  "R1", "recovery 64 Mbit",  r64,  E_RST64);
    check(r32  == E_RST32,  "R1", "recovery 32 Mbit",  r32,  E_RST32);
    for (int L = 0; L <= 60; L++) begin
      do_write(L, L, 1'b0, (L % 3) == 0);
    end
    do_write(61, -1, 1'b1, 1'b0);
    do_write(62, 5, 1'b0, 1'b0);
    do_write(63, -1, 1'b1, 1'b1);
    do_write(64, 57, 1'b0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule